// File: doc/BRIEF.md
# Type-Aware Split Data Memory

This block is the operand memory of an accumulator-style controller CPU. Each request carries a 20-bit word address field, an optional index base to add to it, a 5-bit bit/lane selector and a 4-bit type code. A one-bit override flag decides whether the request's own type code or a stored type register governs the access. Reads return a 32-bit operand: a single bit, a byte, a halfword or a whole word, taken from the addressed word and zero-extended. Writes are typed in the same way. Boolean writes may be plain stores, or conditional set and reset operations driven by bit 0 of the write data.

Storage is split into two regions. The top of the address space holds a small word-wide RAM with asynchronous read, so a read there answers in the request cycle. The top word of that window is a read-only free-running time counter. The bottom of the address space holds four byte-wide synchronous RAM lanes whose outputs form one 32-bit word. A read there answers one clock later, and a single-bit write there is done as a read-modify-write of one lane in the second cycle. The block flags which region a request hits, so the sequencer can stretch the machine cycle to two clocks for the low region.

Top module: `typed_data_mem`

## Requirements
- R1: The effective address is `r_i` when `idx_sel_i` is 0 or 3, `ix_i + r_i` when it is 1, and `iy_i + r_i` when it is 2, all taken modulo 2^20.
- R2: An effective address below BLOCK_DEPTH (default 512) is in the block region, and `slow_o` is 1 for that request. An address at or above 2^20 - FAST_DEPTH (default 32) is in the fast region, and `dram_en_o` is 1. Every other address is unmapped: a read returns 0 with `rvalid_o`, and a write changes nothing.
- R3: A read of the fast or unmapped region gives `rvalid_o` and `rdata_o` in the request cycle. A read of the block region gives them in the following cycle, in which the requester must not issue a request.
- R4: When `d_i` is 1, the access uses `t_i` and the type register loads `t_i`. When `d_i` is 0, the access uses the type register and the register keeps its value. After reset the register holds 0. Type codes: 0 BOOL; 1 and 2 are 8-bit; 3 and 4 are 16-bit; 5 to 15 are 32-bit.
- R5: A BOOL read returns bit `b_i` of the word. An 8-bit read returns byte `b_i[1:0]`, where byte 0 is bits 7:0. A 16-bit read returns the upper half when `b_i[0]` is 1 and the lower half otherwise. A 32-bit read returns the whole word. Narrower results are zero-extended.
- R6: In the block region, an 8-bit store writes only the selected byte and a 16-bit store writes only the selected half, in both cases from the low bits of `wdata_i`. A 32-bit store writes all four bytes.
- R7: A BOOL write to the block region changes only bit `b_i` of the addressed word, with every other bit kept.
- R8: `wmode_i` encodes 0 or 3 as store, 1 as set and 2 as reset. A BOOL store writes `wdata_i[0]`. A set writes 1 and a reset writes 0, but only when `wdata_i[0]` is 1; otherwise the bit is left unchanged. A set or reset with a non-BOOL type changes nothing.
- R9: The fast region serves only BOOL and 32-bit accesses. An 8-bit or 16-bit read there returns 0, and such a write changes nothing.
- R10: Address 0xFFFFF reads a 32-bit counter that increases by one every clock after reset. Writes to it are ignored.
- R11: During and right after reset, `rvalid_o` is 0, `rdata_o` is 0 and `type_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| wmode_i | input | 2 | Write mode: 0/3 store, 1 set, 2 reset |
| idx_sel_i | input | 2 | Address base: 0/3 none, 1 X index, 2 Y index |
| ix_i | input | 20 | X index base |
| iy_i | input | 20 | Y index base |
| r_i | input | 20 | Address or offset field |
| b_i | input | 5 | Bit / lane selector |
| t_i | input | 4 | Type code from the instruction |
| d_i | input | 1 | Type override and type-register load |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Zero-extended read operand |
| rvalid_o | output | 1 | Read operand valid |
| slow_o | output | 1 | Request hits the two-cycle block region |
| dram_en_o | output | 1 | Request hits the single-cycle fast region |
| type_o | output | 4 | Current type register |

## Verification
The assertions assume that the requester leaves the cycle after every block-region request free of requests. That free cycle carries the late read data and the lane read-modify-write. The bench keeps to this because every access task drives a request for one cycle and then holds the request low for one cycle before the next task starts. Inputs change only on falling edges, so the assertions never see a request change in the middle of a cycle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = WORD_W / LANES;
  localparam int unsigned BSEL_W = $clog2(WORD_W);
  localparam int unsigned TYPE_W = 4;

  typedef enum logic [1:0] {CLS_BIT, CLS_BYTE, CLS_HALF, CLS_WORD} size_cls_e;
  typedef enum logic [1:0] {RGN_NONE, RGN_BLOCK, RGN_FAST, RGN_TIMER} region_e;

  // Map a type code onto its access width class.
  function automatic size_cls_e size_class(input logic [TYPE_W-1:0] t);
    case (t)
      4'd0:       return CLS_BIT;
      4'd1, 4'd2: return CLS_BYTE;
      4'd3, 4'd4: return CLS_HALF;
      default:    return CLS_WORD;
    endcase
  endfunction

  // Pick the operand out of a word and zero-extend it.
  function automatic logic [WORD_W-1:0] extract(input logic [WORD_W-1:0] w,
                                                input size_cls_e cls,
                                                input logic [BSEL_W-1:0] b);
    logic [WORD_W-1:0] sh;
    case (cls)
      CLS_BIT: begin
        sh = w >> b;
        return {{(WORD_W-1){1'b0}}, sh[0]};
      end
      CLS_BYTE: begin
        sh = w >> {b[1:0], 3'b000};
        return {{(WORD_W-LANE_W){1'b0}}, sh[LANE_W-1:0]};
      end
      CLS_HALF:
        return b[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
      default:
        return w;
    endcase
  endfunction

  // Byte lanes touched by an access.
  function automatic logic [LANES-1:0] lane_mask(input size_cls_e cls,
                                                 input logic [BSEL_W-1:0] b);
    case (cls)
      CLS_BIT:  return 4'b0001 << b[4:3];
      CLS_BYTE: return 4'b0001 << b[1:0];
      CLS_HALF: return b[0] ? 4'b1100 : 4'b0011;
      default:  return 4'b1111;
    endcase
  endfunction

  // Replicate narrow store data onto every lane position.
  function automatic logic [WORD_W-1:0] spread(input logic [WORD_W-1:0] w,
                                               input size_cls_e cls);
    case (cls)
      CLS_BYTE: return {LANES{w[LANE_W-1:0]}};
      CLS_HALF: return {2{w[15:0]}};
      default:  return w;
    endcase
  endfunction

  // Boolean write decision: {write_enable, bit_value}.
  function automatic logic [1:0] bool_write(input logic [1:0] wmode,
                                            input logic cond);
    case (wmode)
      2'd1:    return {cond, 1'b1};
      2'd2:    return {cond, 1'b0};
      default: return {1'b1, cond};
    endcase
  endfunction

  // Replace one bit inside a byte.
  function automatic logic [LANE_W-1:0] patch_byte(input logic [LANE_W-1:0] old,
                                                   input logic [2:0] pos,
                                                   input logic val);
    logic [LANE_W-1:0] m;
    m = 8'h01 << pos;
    return val ? (old | m) : (old & ~m);
  endfunction
endpackage

// File: rtl/tdm_addr_dec.sv
module tdm_addr_dec
  import tdm_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_DEPTH = 512,
  parameter int FAST_DEPTH  = 32,
  localparam int BAW = $clog2(BLOCK_DEPTH),
  localparam int FAW = $clog2(FAST_DEPTH)
) (
  input  logic [1:0]        idx_sel,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  input  logic [ADDR_W-1:0] r,
  output region_e           region,
  output logic [BAW-1:0]    blk_idx,
  output logic [FAW-1:0]    fast_idx
);
  localparam int FAST_BASE_I = (1 << ADDR_W) - FAST_DEPTH;
  localparam logic [ADDR_W-1:0] FAST_BASE = FAST_BASE_I[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BLOCK_LIM = BLOCK_DEPTH[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;

  logic [ADDR_W-1:0] ea;

  always_comb begin
    case (idx_sel)
      2'd1:    ea = ix + r;
      2'd2:    ea = iy + r;
      default: ea = r;
    endcase
  end

  always_comb begin
    if (ea == TOP_ADDR)        region = RGN_TIMER;
    else if (ea >= FAST_BASE)  region = RGN_FAST;
    else if (ea < BLOCK_LIM)   region = RGN_BLOCK;
    else                       region = RGN_NONE;
  end

  assign blk_idx  = ea[BAW-1:0];
  assign fast_idx = ea[FAW-1:0];
endmodule

// File: rtl/tdm_fast_ram.sv
module tdm_fast_ram
  import tdm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= (mem[idx] & ~mask) | (wdata & mask);
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/tdm_block_lanes.sv
module tdm_block_lanes
  import tdm_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      q[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/typed_data_mem.sv
module typed_data_mem
  import tdm_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLOCK_DEPTH = 512,
  parameter int FAST_DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [1:0]        wmode_i,
  input  logic [1:0]        idx_sel_i,
  input  logic [ADDR_W-1:0] ix_i,
  input  logic [ADDR_W-1:0] iy_i,
  input  logic [ADDR_W-1:0] r_i,
  input  logic [4:0]        b_i,
  input  logic [3:0]        t_i,
  input  logic              d_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              slow_o,
  output logic              dram_en_o,
  output logic [3:0]        type_o
);
  localparam int BAW = $clog2(BLOCK_DEPTH);
  localparam int FAW = $clog2(FAST_DEPTH);

  logic [TYPE_W-1:0] type_q;
  logic [TYPE_W-1:0] eff_type;
  size_cls_e         cls;
  region_e           region;
  logic [BAW-1:0]    blk_idx;
  logic [FAW-1:0]    fast_idx;
  logic [WORD_W-1:0] sys_time;

  assign eff_type = d_i ? t_i : type_q;
  assign cls      = size_class(eff_type);
  assign type_o   = type_q;

  tdm_addr_dec #(
    .ADDR_W(ADDR_W), .BLOCK_DEPTH(BLOCK_DEPTH), .FAST_DEPTH(FAST_DEPTH)
  ) u_dec (
    .idx_sel(idx_sel_i), .ix(ix_i), .iy(iy_i), .r(r_i),
    .region(region), .blk_idx(blk_idx), .fast_idx(fast_idx)
  );

  logic hit_block, hit_fast, hit_store, is_store;
  logic [1:0] bw;
  assign hit_block = req_i && (region == RGN_BLOCK);
  assign hit_fast  = req_i && (region == RGN_FAST);
  assign hit_store = req_i && wr_i;
  assign is_store  = (wmode_i == 2'd0) || (wmode_i == 2'd3);
  assign bw        = bool_write(wmode_i, wdata_i[0]);

  assign slow_o    = hit_block;
  assign dram_en_o = req_i && ((region == RGN_FAST) || (region == RGN_TIMER));

  // Type register and time counter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q   <= '0;
      sys_time <= '0;
    end else begin
      sys_time <= sys_time + 1'b1;
      if (req_i && d_i) type_q <= t_i;
    end
  end

  // Fast region: single-cycle, BOOL and 32-bit only.
  logic              fast_we;
  logic [WORD_W-1:0] fast_mask, fast_wd, fast_rd;

  always_comb begin
    fast_we   = 1'b0;
    fast_mask = '1;
    fast_wd   = wdata_i;
    if (hit_fast && wr_i) begin
      if (cls == CLS_BIT) begin
        fast_we   = bw[1];
        fast_mask = 32'd1 << b_i;
        fast_wd   = {WORD_W{bw[0]}};
      end else if (cls == CLS_WORD) begin
        fast_we   = is_store;
      end
    end
  end

  tdm_fast_ram #(.DEPTH(FAST_DEPTH)) u_fast (
    .clk(clk), .we(fast_we), .idx(fast_idx),
    .mask(fast_mask), .wdata(fast_wd), .rdata(fast_rd)
  );

  // Block region: pending read and pending bit read-modify-write.
  logic              rd_pend_q;
  size_cls_e         rd_cls_q;
  logic [4:0]        rd_b_q;
  logic              rmw_q;
  logic [BAW-1:0]    rmw_addr_q;
  logic [4:0]        rmw_b_q;
  logic              rmw_val_q;
  logic              rmw_start, direct_wr;

  assign direct_wr = hit_block && hit_store && (cls != CLS_BIT) && is_store;
  assign rmw_start = hit_block && hit_store && (cls == CLS_BIT) && bw[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      rd_cls_q   <= CLS_BIT;
      rd_b_q     <= '0;
      rmw_q      <= 1'b0;
      rmw_addr_q <= '0;
      rmw_b_q    <= '0;
      rmw_val_q  <= 1'b0;
    end else begin
      rd_pend_q <= hit_block && !wr_i;
      rmw_q     <= rmw_start;
      if (hit_block && !wr_i) begin
        rd_cls_q <= cls;
        rd_b_q   <= b_i;
      end
      if (rmw_start) begin
        rmw_addr_q <= blk_idx;
        rmw_b_q    <= b_i;
        rmw_val_q  <= bw[0];
      end
    end
  end

  logic [BAW-1:0]    port_addr;
  logic [LANES-1:0]  port_we;
  logic [WORD_W-1:0] port_wd, blk_q, old_sh;
  logic [LANE_W-1:0] patched;

  assign old_sh  = blk_q >> {rmw_b_q[4:3], 3'b000};
  assign patched = patch_byte(old_sh[LANE_W-1:0], rmw_b_q[2:0], rmw_val_q);

  always_comb begin
    if (rmw_q) begin
      port_addr = rmw_addr_q;
      port_we   = lane_mask(CLS_BIT, rmw_b_q);
      port_wd   = {LANES{patched}};
    end else begin
      port_addr = blk_idx;
      port_we   = direct_wr ? lane_mask(cls, b_i) : '0;
      port_wd   = spread(wdata_i, cls);
    end
  end

  tdm_block_lanes #(.DEPTH(BLOCK_DEPTH)) u_lanes (
    .clk(clk), .addr(port_addr), .lane_we(port_we), .wdata(port_wd), .q(blk_q)
  );

  // Read return.
  logic [WORD_W-1:0] fast_word;
  logic              fast_ok, fast_src;
  assign fast_word = (region == RGN_TIMER) ? sys_time : fast_rd;
  assign fast_ok   = (cls == CLS_BIT) || (cls == CLS_WORD);
  assign fast_src  = (region == RGN_FAST) || (region == RGN_TIMER);

  always_comb begin
    rvalid_o = 1'b0;
    rdata_o  = '0;
    if (rd_pend_q) begin
      rvalid_o = 1'b1;
      rdata_o  = extract(blk_q, rd_cls_q, rd_b_q);
    end else if (req_i && !wr_i && (region != RGN_BLOCK)) begin
      rvalid_o = 1'b1;
      if (fast_src && fast_ok) rdata_o = extract(fast_word, cls, b_i);
    end
  end
endmodule

// File: rtl/tdm_checker.sv
module tdm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        wr_i,
  input logic        d_i,
  input logic [3:0]  t_i,
  input logic [31:0] rdata_o,
  input logic        rvalid_o,
  input logic        slow_o,
  input logic        dram_en_o,
  input logic [3:0]  type_o,
  input logic [3:0]  eff_type,
  input logic [31:0] sys_time,
  input logic        rmw_q
);
  assert_regions_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(slow_o && dram_en_o));

  assert_fast_read_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && !slow_o) |-> rvalid_o);

  assert_block_read_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && slow_o) |=> rvalid_o);

  assert_block_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slow_o |=> !req_i);

  assert_type_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && d_i) |=> (type_o == $past(t_i)));

  assert_type_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && d_i) |=> $stable(type_o));

  assert_bool_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && !slow_o && eff_type == 4'd0) |-> (rdata_o[31:1] == 31'd0));

  assert_block_bool_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && slow_o && eff_type == 4'd0) |=> (rdata_o[31:1] == 31'd0));

  assert_rmw_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_q |=> !rmw_q);

  assert_timer_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (sys_time == $past(sys_time) + 32'd1));

  assert_idle_reset_R11: assert property (@(posedge clk)
    !rst_n |=> (!rvalid_o || req_i));
endmodule

bind typed_data_mem tdm_checker u_tdm_checker (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .d_i(d_i), .t_i(t_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .slow_o(slow_o), .dram_en_o(dram_en_o),
  .type_o(type_o), .eff_type(eff_type), .sys_time(sys_time), .rmw_q(rmw_q)
);

// File: tb/test_typed_data_mem.sv
module test_typed_data_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0, d_i = 1'b0;
  logic [1:0]  wmode_i = '0, idx_sel_i = '0;
  logic [19:0] ix_i = '0, iy_i = '0, r_i = '0;
  logic [4:0]  b_i = '0;
  logic [3:0]  t_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, slow_o, dram_en_o;
  logic [3:0]  type_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  typed_data_mem i_typed_data_mem (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .wmode_i(wmode_i),
    .idx_sel_i(idx_sel_i), .ix_i(ix_i), .iy_i(iy_i), .r_i(r_i), .b_i(b_i),
    .t_i(t_i), .d_i(d_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .slow_o(slow_o), .dram_en_o(dram_en_o), .type_o(type_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request cycle followed by one free cycle.
  task automatic acc(input bit wr, input logic [1:0] wm, input logic [1:0] isel,
                     input logic [19:0] r, input logic [4:0] b, input logic [3:0] t,
                     input bit d, input logic [31:0] wd,
                     output logic [31:0] rd, output logic rv,
                     output logic slow, output logic fen);
    logic [31:0] rd0;
    logic rv0;
    @(negedge clk);
    req_i = 1'b1; wr_i = wr; wmode_i = wm; idx_sel_i = isel; r_i = r;
    b_i = b; t_i = t; d_i = d; wdata_i = wd;
    #2;
    rd0 = rdata_o; rv0 = rvalid_o; slow = slow_o; fen = dram_en_o;
    @(negedge clk);
    req_i = 1'b0; wr_i = 1'b0; d_i = 1'b0;
    #2;
    if (slow) begin rd = rdata_o; rv = rvalid_o; end
    else begin rd = rd0; rv = rv0; end
  endtask

  task automatic wr_t(input logic [19:0] a, input logic [3:0] t, input logic [4:0] b,
                      input logic [1:0] wm, input logic [31:0] v);
    logic [31:0] rd; logic rv, s, f;
    acc(1'b1, wm, 2'd0, a, b, t, 1'b1, v, rd, rv, s, f);
  endtask

  task automatic rd_t(input logic [19:0] a, input logic [3:0] t, input logic [4:0] b,
                      output logic [31:0] v);
    logic rv, s, f;
    acc(1'b0, 2'd0, 2'd0, a, b, t, 1'b1, '0, v, rv, s, f);
  endtask

  task automatic t_reset();
    #2;
    check("R11 rvalid", {31'd0, rvalid_o}, 32'd0);
    check("R11 rdata", rdata_o, 32'd0);
    check("R11 type", {28'd0, type_o}, 32'd0);
  endtask

  task automatic t_lanes();
    logic [31:0] v; logic rv, s, f;
    wr_t(20'h7, 4'd5, 5'd0, 2'd0, 32'h11223344);
    acc(1'b0, 2'd0, 2'd0, 20'h7, 5'd0, 4'd5, 1'b1, '0, v, rv, s, f);
    check("R3 block read late", v, 32'h11223344);
    check("R3 block rvalid", {31'd0, rv}, 32'd1);
    check("R2 block slow", {30'd0, s, f}, 32'd2);
    wr_t(20'h7, 4'd1, 5'd2, 2'd0, 32'hFFFF_FFAB);
    rd_t(20'h7, 4'd5, 5'd0, v);
    check("R6 byte lane", v, 32'h11AB3344);
    wr_t(20'h7, 4'd4, 5'd1, 2'd0, 32'h1234BEEF);
    rd_t(20'h7, 4'd5, 5'd0, v);
    check("R6 half lane", v, 32'hBEEF3344);
    rd_t(20'h7, 4'd2, 5'd0, v);
    check("R5 byte0", v, 32'h44);
    rd_t(20'h7, 4'd3, 5'd1, v);
    check("R5 half hi", v, 32'hBEEF);
    rd_t(20'h7, 4'd0, 5'd31, v);
    check("R5 bool bit31", v, 32'd1);
    rd_t(20'h7, 4'd0, 5'd2, v);
    check("R5 bool bit2", v, 32'd1);
    rd_t(20'h7, 4'd0, 5'd3, v);
    check("R5 bool bit3", v, 32'd0);
  endtask

  task automatic t_bits();
    logic [31:0] v;
    wr_t(20'h40, 4'd6, 5'd0, 2'd0, 32'hF0F00000);
    wr_t(20'h40, 4'd0, 5'd3, 2'd0, 32'h1);
    wr_t(20'h40, 4'd0, 5'd31, 2'd0, 32'h0);
    rd_t(20'h40, 4'd6, 5'd0, v);
    check("R7 bool store rmw", v, 32'h70F00008);
    wr_t(20'h40, 4'd0, 5'd13, 2'd1, 32'h1);
    wr_t(20'h40, 4'd0, 5'd2, 2'd1, 32'h0);
    rd_t(20'h40, 4'd6, 5'd0, v);
    check("R8 set", v, 32'h70F02008);
    wr_t(20'h40, 4'd0, 5'd20, 2'd2, 32'h1);
    wr_t(20'h40, 4'd0, 5'd13, 2'd2, 32'h0);
    wr_t(20'h40, 4'd1, 5'd0, 2'd1, 32'h1);
    rd_t(20'h40, 4'd6, 5'd0, v);
    check("R8 reset and ignored", v, 32'h70E02008);
    rd_t(20'h40, 4'd0, 5'd13, v);
    check("R7 bit13", v, 32'd1);
  endtask

  task automatic t_fast();
    logic [31:0] v; logic rv, s, f;
    wr_t(20'hFFFE3, 4'd5, 5'd0, 2'd0, 32'hA5A50F0F);
    acc(1'b0, 2'd0, 2'd0, 20'hFFFE3, 5'd0, 4'd5, 1'b1, '0, v, rv, s, f);
    check("R3 fast read", v, 32'hA5A50F0F);
    check("R2 fast flags", {30'd0, s, f}, 32'd1);
    rd_t(20'hFFFE3, 4'd0, 5'd8, v);
    check("R5 fast bool8", v, 32'd1);
    wr_t(20'hFFFE3, 4'd0, 5'd4, 2'd0, 32'h1);
    wr_t(20'hFFFE3, 4'd1, 5'd0, 2'd0, 32'h77);
    wr_t(20'hFFFE3, 4'd3, 5'd0, 2'd0, 32'h5555);
    rd_t(20'hFFFE3, 4'd1, 5'd0, v);
    check("R9 fast byte read zero", v, 32'd0);
    rd_t(20'hFFFE3, 4'd5, 5'd0, v);
    check("R9 fast subword write ignored", v, 32'hA5A50F1F);
    wr_t(20'hFFFE3, 4'd0, 5'd31, 2'd2, 32'h1);
    rd_t(20'hFFFE3, 4'd5, 5'd0, v);
    check("R8 fast reset", v, 32'h25A50F1F);
  endtask

  task automatic t_index();
    logic [31:0] v; logic rv, s, f;
    wr_t(20'h123, 4'd5, 5'd0, 2'd0, 32'hDEAD0123);
    ix_i = 20'h100;
    acc(1'b0, 2'd0, 2'd1, 20'h23, 5'd0, 4'd5, 1'b1, '0, v, rv, s, f);
    check("R1 ix read", v, 32'hDEAD0123);
    iy_i = 20'hFFFF0;
    acc(1'b1, 2'd0, 2'd2, 20'h5, 5'd0, 4'd5, 1'b1, 32'h0BADCAFE, v, rv, s, f);
    check("R1 iy fast flag", {31'd0, f}, 32'd1);
    rd_t(20'hFFFF5, 4'd5, 5'd0, v);
    check("R1 iy write", v, 32'h0BADCAFE);
    iy_i = 20'hFFFFF;
    acc(1'b1, 2'd0, 2'd2, 20'h6, 5'd0, 4'd5, 1'b1, 32'h600D0005, v, rv, s, f);
    rd_t(20'h5, 4'd5, 5'd0, v);
    check("R1 wrap", v, 32'h600D0005);
    acc(1'b0, 2'd0, 2'd3, 20'h123, 5'd0, 4'd5, 1'b1, '0, v, rv, s, f);
    check("R1 sel3 direct", v, 32'hDEAD0123);
  endtask

  task automatic t_type();
    logic [31:0] v; logic rv, s, f;
    wr_t(20'h9, 4'd5, 5'd0, 2'd0, 32'hCAFEF00D);
    rd_t(20'h9, 4'd1, 5'd1, v);
    check("R4 override byte", v, 32'hF0);
    check("R4 type loaded", {28'd0, type_o}, 32'd1);
    acc(1'b0, 2'd0, 2'd0, 20'h9, 5'd3, 4'd5, 1'b0, '0, v, rv, s, f);
    check("R4 stored byte", v, 32'hCA);
    check("R4 type kept", {28'd0, type_o}, 32'd1);
    rd_t(20'h9, 4'd3, 5'd1, v);
    check("R4 override half", v, 32'hCAFE);
    acc(1'b0, 2'd0, 2'd0, 20'h9, 5'd0, 4'd0, 1'b0, '0, v, rv, s, f);
    check("R4 stored half", v, 32'hF00D);
  endtask

  task automatic t_timer();
    logic [31:0] a, b2;
    rd_t(20'hFFFFF, 4'd5, 5'd0, a);
    rd_t(20'hFFFFF, 4'd5, 5'd0, b2);
    check("R10 timer step", b2 - a, 32'd2);
    wr_t(20'hFFFFF, 4'd5, 5'd0, 2'd0, 32'h0);
    rd_t(20'hFFFFF, 4'd5, 5'd0, a);
    check("R10 timer write ignored", a - b2, 32'd4);
  endtask

  task automatic t_unmapped();
    logic [31:0] v; logic rv, s, f;
    wr_t(20'h40000, 4'd5, 5'd0, 2'd0, 32'h12345678);
    acc(1'b0, 2'd0, 2'd0, 20'h40000, 5'd0, 4'd5, 1'b1, '0, v, rv, s, f);
    check("R2 unmapped data", v, 32'd0);
    check("R2 unmapped flags", {29'd0, rv, s, f}, 32'd4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_lanes();
    t_bits();
    t_fast();
    t_index();
    t_type();
    t_timer();
    t_unmapped();
    finish_run();
  end
endmodule